// File: doc/BRIEF.md
# Two-Way Multi-Channel Mailbox

This block lets two processors, called side A and side B, pass short messages to each other through a small set of registers. There are two directions: A toward B and B toward A. Each direction has a command word and a data word for every channel, plus one interrupt-enable register and one status register. The sender writes the command word first and the data word second. The data write marks the message as complete by setting that channel's status bit. The receiver sees an interrupt line for that channel while both the status bit and the enable bit are set. The receiver then reads the words and clears the status bit by writing a one to it.

Each side has its own 32-bit register port with address, write enable, write data and registered read data. Both ports can reach every register of both directions. The two directions have the same layout. The second direction starts at a fixed distance from the first, so software for one side can be reused for the other by moving a base offset.

Top module: `mailbox_duplex`

## Requirements
- R1: After a synchronous reset, every register reads zero and every interrupt line is low.
- R2: Byte-address map for the A-to-B direction: enable at 0x00, status at 0x04, command of channel x at 0x08+8x, data of channel x at 0x0C+8x. The B-to-A direction has the same layout starting at 0x28: enable 0x28, status 0x2C, command 0x30+8x, data 0x34+8x. Command and data words store and return all 32 bits.
- R3: Writing a channel's data word sets status bit x (bit x for channel x) in that direction's status register. Writing the command word does not touch the status register.
- R4: For the status register, a written 1 in bit x clears bit x, and a written 0 leaves the bit as it was.
- R5: The enable register keeps bits [3:0], one per channel, and reads zeros above them. Writing 0xF enables every channel, and writing 0 disables them all.
- R6: Interrupt line x toward side B (irq_to_b[x]) is high exactly while A-to-B status bit x and A-to-B enable bit x are both set. The same rule links irq_to_a[x] to the B-to-A status and enable bits. Enable does not change the stored status.
- R7: When a status clear and a data write for the same channel land in the same cycle, the status bit ends up set.
- R8: Offsets outside 0x00..0x4F, and offsets that are not multiples of 4, read as zero. Writes to them change no register.
- R9: Read data appears on a port's read-data output on the clock edge that samples the address, and it holds until the next edge.
- R10: When both ports write the same word in one cycle, side A's value is kept. Status sets and clears from both ports in one cycle all take effect together.
- R11: Messages, status and enables in one direction never affect the other direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 8 | Side A byte address |
| a_we | input | 1 | Side A write enable |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A registered read data |
| b_addr | input | 8 | Side B byte address |
| b_we | input | 1 | Side B write enable |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B registered read data |
| irq_to_b | output | 4 | Per-channel interrupt toward side B (A-to-B messages) |
| irq_to_a | output | 4 | Per-channel interrupt toward side A (B-to-A messages) |

## Verification
Two events can fall in the same cycle. The first is a receiver clearing a status bit while the sender completes a new message on that channel. The second is both ports writing the same word. The bench triggers the first by driving a status clear on port A and the data write for the same channel on port B in the same clock. It then judges the result by reading back the status bit and watching the interrupt line, both of which must stay set. It triggers the second by having both ports write one command word in the same cycle; side A's value must be the one read back. It also has both ports complete messages on different channels in the same cycle, and both status bits must then appear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // register kind within one direction's window
  typedef enum logic [1:0] {
    K_EN  = 2'd0,
    K_ST  = 2'd1,
    K_CMD = 2'd2,
    K_DAT = 2'd3
  } kind_e;

  localparam int unsigned NPORT = 2;  // side A = 0, side B = 1
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int unsigned AW  = 8,
  parameter int unsigned NCH = 4
) (
  input  logic [AW-1:0]     addr_i,
  output logic              valid_o,
  output logic              dir_o,
  output mbx_pkg::kind_e    kind_o,
  output logic [AW-1:0]     chan_o
);
  import mbx_pkg::*;

  localparam int unsigned SPAN_I = 8 + 8 * NCH;
  localparam logic [AW-1:0] SPAN = AW'(SPAN_I);
  localparam logic [AW:0]   TOP  = (AW+1)'(2 * SPAN_I);

  logic [AW-1:0] off;
  logic [AW-1:0] rel;

  always_comb begin
    valid_o = 1'b0;
    dir_o   = 1'b0;
    kind_o  = K_EN;
    chan_o  = '0;
    off     = addr_i;
    rel     = '0;
    if (addr_i >= SPAN) begin
      dir_o = 1'b1;
      off   = addr_i - SPAN;
    end
    if (({1'b0, addr_i} < TOP) && (addr_i[1:0] == 2'b00)) begin
      valid_o = 1'b1;
      if (off == AW'(0)) begin
        kind_o = K_EN;
      end else if (off == AW'(4)) begin
        kind_o = K_ST;
      end else begin
        rel    = off - AW'(8);
        chan_o = rel >> 3;
        kind_o = rel[2] ? K_DAT : K_CMD;
      end
    end
  end

  // R2: a decoded word register always names an existing channel
  always_comb begin
    p_chan_range_r2: assert (!valid_o || kind_o == K_EN || kind_o == K_ST ||
                             chan_o < AW'(NCH));
  end
endmodule

// File: rtl/mbx_dir.sv
module mbx_dir #(
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned NCH = 4,
  parameter int unsigned NP  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NP-1:0]                sel_i,
  input  logic [NP-1:0]                we_i,
  input  mbx_pkg::kind_e [NP-1:0]      kind_i,
  input  logic [NP-1:0][AW-1:0]        chan_i,
  input  logic [NP-1:0][DW-1:0]        wdata_i,
  output logic [NP-1:0][DW-1:0]        rdata_o,
  output logic [NCH-1:0]               irq_o
);
  import mbx_pkg::*;

  logic [DW-1:0]  cmd_q [NCH];
  logic [DW-1:0]  dat_q [NCH];
  logic [NCH-1:0] en_q, st_q;
  logic [NCH-1:0] set_v, clr_v;
  logic           en_wr;

  // status set / clear vectors gathered from every port
  always_comb begin
    set_v = '0;
    clr_v = '0;
    en_wr = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (sel_i[p] && we_i[p]) begin
        if (kind_i[p] == K_ST) clr_v = clr_v | wdata_i[p][NCH-1:0];
        if (kind_i[p] == K_EN) en_wr = 1'b1;
        for (int c = 0; c < NCH; c++) begin
          if (kind_i[p] == K_DAT && chan_i[p] == AW'(c)) set_v[c] = 1'b1;
        end
      end
    end
  end

  // enable and status; port 0 (side A) written last so it wins
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      st_q <= (st_q & ~clr_v) | set_v;
      for (int p = NP - 1; p >= 0; p--) begin
        if (sel_i[p] && we_i[p] && kind_i[p] == K_EN) en_q <= wdata_i[p][NCH-1:0];
      end
    end
  end

  // per-channel word pair
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        cmd_q[c] <= '0;
        dat_q[c] <= '0;
      end else begin
        for (int p = NP - 1; p >= 0; p--) begin
          if (sel_i[p] && we_i[p] && chan_i[p] == AW'(c)) begin
            if (kind_i[p] == K_CMD) cmd_q[c] <= wdata_i[p];
            if (kind_i[p] == K_DAT) dat_q[c] <= wdata_i[p];
          end
        end
      end
    end

    // R3: a completed message leaves the status bit set
    p_data_sets_status_r3: assert property (@(posedge clk) disable iff (rst)
      set_v[c] |=> st_q[c]);
    // R4: a status bit only drops after a clear request for it
    p_status_falls_on_clear_r4: assert property (@(posedge clk) disable iff (rst)
      $fell(st_q[c]) |-> $past(clr_v[c]));
    // R7: concurrent set and clear keep the bit
    p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
      (set_v[c] && clr_v[c]) |=> st_q[c]);
  end

  assign irq_o = st_q & en_q;

  // read mux per port
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      rdata_o[p] = '0;
      case (kind_i[p])
        K_EN: rdata_o[p] = DW'(en_q);
        K_ST: rdata_o[p] = DW'(st_q);
        default: begin
          for (int c = 0; c < NCH; c++) begin
            if (chan_i[p] == AW'(c))
              rdata_o[p] = (kind_i[p] == K_DAT) ? dat_q[c] : cmd_q[c];
          end
        end
      endcase
    end
  end

  // R5: the enable register holds without a write
  p_enable_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !en_wr |=> $stable(en_q));
  // R1: reset empties status and enable
  p_reset_clears_r1: assert property (@(posedge clk)
    $past(rst) |-> (st_q == '0 && en_q == '0));
endmodule

// File: rtl/mailbox_duplex.sv
module mailbox_duplex #(
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  a_addr,
  input  logic           a_we,
  input  logic [DW-1:0]  a_wdata,
  output logic [DW-1:0]  a_rdata,
  input  logic [AW-1:0]  b_addr,
  input  logic           b_we,
  input  logic [DW-1:0]  b_wdata,
  output logic [DW-1:0]  b_rdata,
  output logic [NCH-1:0] irq_to_b,
  output logic [NCH-1:0] irq_to_a
);
  import mbx_pkg::*;

  localparam int unsigned NP = NPORT;

  logic [NP-1:0][AW-1:0]       addr_p;
  logic [NP-1:0]               we_p;
  logic [NP-1:0][DW-1:0]       wdata_p;
  logic [NP-1:0]               valid_p, dir_p;
  kind_e [NP-1:0]              kind_p;
  logic [NP-1:0][AW-1:0]       chan_p;
  logic [1:0][NP-1:0][DW-1:0]  rd_all;
  logic [1:0][NCH-1:0]         irq_all;
  logic [NP-1:0][DW-1:0]       rdata_q;

  assign addr_p  = {b_addr, a_addr};
  assign we_p    = {b_we, a_we};
  assign wdata_p = {b_wdata, a_wdata};

  for (genvar p = 0; p < NP; p++) begin : g_port
    mbx_decode #(.AW(AW), .NCH(NCH)) u_dec (
      .addr_i  (addr_p[p]),
      .valid_o (valid_p[p]),
      .dir_o   (dir_p[p]),
      .kind_o  (kind_p[p]),
      .chan_o  (chan_p[p])
    );

    always_ff @(posedge clk) begin
      if (rst)              rdata_q[p] <= '0;
      else if (valid_p[p])  rdata_q[p] <= rd_all[dir_p[p]][p];
      else                  rdata_q[p] <= '0;
    end

    // R8: an unmapped address yields zero read data
    p_rdata_zero_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
      !valid_p[p] |=> rdata_q[p] == '0);
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [NP-1:0] sel;
    for (genvar p = 0; p < NP; p++) begin : g_sel
      assign sel[p] = valid_p[p] && (dir_p[p] == d[0]);
    end

    mbx_dir #(.AW(AW), .DW(DW), .NCH(NCH), .NP(NP)) u_dir (
      .clk     (clk),
      .rst     (rst),
      .sel_i   (sel),
      .we_i    (we_p),
      .kind_i  (kind_p),
      .chan_i  (chan_p),
      .wdata_i (wdata_p),
      .rdata_o (rd_all[d]),
      .irq_o   (irq_all[d])
    );
  end

  assign a_rdata  = rdata_q[0];
  assign b_rdata  = rdata_q[1];
  assign irq_to_b = irq_all[0];
  assign irq_to_a = irq_all[1];
endmodule

// File: tb/mailbox_duplex_tb.sv
module mailbox_duplex_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  a_addr = '0, b_addr = '0;
  logic        a_we = 1'b0, b_we = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic [3:0]  irq_to_b, irq_to_a;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mailbox_duplex u_dut (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq_to_b(irq_to_b), .irq_to_a(irq_to_a)
  );

  // {read, side_b, req, addr, data}; reads compare, writes drive
  localparam int NV = 26;
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'd2,  8'h08, 32'hCAFE0001},  // R2 A2B cmd0
    {1'b1, 1'b1, 4'd2,  8'h08, 32'hCAFE0001},  // R2
    {1'b1, 1'b0, 4'd3,  8'h04, 32'h00000000},  // R3 cmd sets nothing
    {1'b0, 1'b0, 4'd3,  8'h0C, 32'h00000010},  // R3 data0
    {1'b1, 1'b1, 4'd2,  8'h0C, 32'h00000010},  // R2
    {1'b1, 1'b1, 4'd3,  8'h04, 32'h00000001},  // R3
    {1'b0, 1'b1, 4'd3,  8'h24, 32'h00005A5A},  // R3 data3
    {1'b1, 1'b0, 4'd3,  8'h04, 32'h00000009},  // R3
    {1'b0, 1'b1, 4'd4,  8'h04, 32'h00000001},  // R4 clear ch0
    {1'b1, 1'b0, 4'd4,  8'h04, 32'h00000008},  // R4
    {1'b0, 1'b1, 4'd4,  8'h04, 32'h00000000},  // R4 zeros keep
    {1'b1, 1'b0, 4'd4,  8'h04, 32'h00000008},  // R4
    {1'b0, 1'b1, 4'd11, 8'h3C, 32'h00000077},  // R11 B2A data1
    {1'b1, 1'b0, 4'd11, 8'h2C, 32'h00000002},  // R11
    {1'b1, 1'b0, 4'd11, 8'h04, 32'h00000008},  // R11
    {1'b1, 1'b1, 4'd2,  8'h3C, 32'h00000077},  // R2
    {1'b0, 1'b0, 4'd5,  8'h00, 32'hFFFFFFFF},  // R5
    {1'b1, 1'b1, 4'd5,  8'h00, 32'h0000000F},  // R5
    {1'b0, 1'b0, 4'd8,  8'h50, 32'h12345678},  // R8 beyond map
    {1'b1, 1'b0, 4'd8,  8'h50, 32'h00000000},  // R8
    {1'b0, 1'b0, 4'd8,  8'h09, 32'hDEADBEEF},  // R8 misaligned
    {1'b1, 1'b0, 4'd8,  8'h08, 32'hCAFE0001},  // R8
    {1'b1, 1'b0, 4'd8,  8'h09, 32'h00000000},  // R8
    {1'b0, 1'b1, 4'd2,  8'h30, 32'hABCD0000},  // R2 B2A cmd0
    {1'b1, 1'b0, 4'd2,  8'h30, 32'hABCD0000},  // R2
    {1'b1, 1'b0, 4'd3,  8'h2C, 32'h00000002}   // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input bit side, input bit w, input logic [7:0] addr,
                    input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    if (side) begin b_addr = addr; b_we = w; b_wdata = d; a_we = 1'b0; end
    else      begin a_addr = addr; a_we = w; a_wdata = d; b_we = 1'b0; end
    @(posedge clk); #1;
    r = side ? b_rdata : a_rdata;
    a_we = 1'b0; b_we = 1'b0;
  endtask

  task automatic dual(input logic [7:0] aa, input logic [31:0] ad,
                      input logic [7:0] ba, input logic [31:0] bd);
    @(negedge clk);
    a_addr = aa; a_wdata = ad; a_we = 1'b1;
    b_addr = ba; b_wdata = bd; b_we = 1'b1;
    @(posedge clk); #1;
    a_we = 1'b0; b_we = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 irq_to_b", 32'(irq_to_b), 32'h0);
    chk("R1 irq_to_a", 32'(irq_to_a), 32'h0);
    op(0, 0, 8'h04, 0, r); chk("R1 status", r, 32'h0);
    op(1, 0, 8'h2C, 0, r); chk("R1 status b2a", r, 32'h0);
    op(0, 0, 8'h30, 0, r); chk("R1 cmd", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][44], ~VEC[i][45], VEC[i][39:32], VEC[i][31:0], r);
      if (VEC[i][45]) chk($sformatf("R%0d vec%0d", VEC[i][43:40], i), r, VEC[i][31:0]);
    end

    // R6 interrupt gating
    chk("R6 irq_to_b", 32'(irq_to_b), 32'h8);
    chk("R6 irq_to_a off", 32'(irq_to_a), 32'h0);
    op(1, 1, 8'h28, 32'h2, r);
    chk("R6 irq_to_a on", 32'(irq_to_a), 32'h2);
    op(0, 1, 8'h00, 32'h0, r);
    chk("R5 disable all", 32'(irq_to_b), 32'h0);
    op(0, 0, 8'h04, 0, r); chk("R6 status kept", r, 32'h8);

    // R7 set beats clear on one channel
    op(0, 1, 8'h00, 32'hF, r);
    dual(8'h04, 32'h8, 8'h24, 32'h1);
    op(1, 0, 8'h04, 0, r); chk("R7 status", r, 32'h8);
    chk("R7 irq", 32'(irq_to_b), 32'h8);
    op(0, 1, 8'h04, 32'h8, r);
    op(1, 0, 8'h04, 0, r); chk("R4 clear alone", r, 32'h0);
    chk("R6 irq drop", 32'(irq_to_b), 32'h0);

    // R10 concurrent writes
    dual(8'h08, 32'h11111111, 8'h08, 32'h22222222);
    op(1, 0, 8'h08, 0, r); chk("R10 side A wins", r, 32'h11111111);
    dual(8'h0C, 32'h1, 8'h14, 32'h2);
    op(0, 0, 8'h04, 0, r); chk("R10 both sets", r, 32'h3);

    // R9 read latency
    op(0, 0, 8'h08, 0, r);
    @(negedge clk); a_addr = 8'h04; #1;
    chk("R9 hold before edge", a_rdata, 32'h11111111);
    @(posedge clk); #1;
    chk("R9 after edge", a_rdata, 32'h3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule